// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the column addresses of that burst, one address per clock, for a DRAM page of 256 columns. A request is a one-cycle start strobe with a starting column, the access direction and the mode fields decoded from the memory's configuration. These fields are a three-bit burst length code, an order bit (sequential or interleaved) and a single-write bit. The block presents each column with a valid flag. A last flag marks the final beat of every fixed-length burst.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block that contains the starting column. In sequential order the low bits count up and wrap. In interleaved order they are the starting offset XORed with the beat number. A full-page burst walks the whole row, wraps from the top column to column 0, and runs until a terminate input stops it. A length or order setting that is not allowed raises an error flag, and the access is reduced to a single beat.

Top module: `burst_colgen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `valid`, `last` and `mode_err` are 0.
- R2: A `start` sampled at a clock edge makes `valid` 1 from the next cycle on, with `col` equal to `start_col` on that first beat and one new beat on each later clock.
- R3: Sequential order (`interleave`=0) with length code 001, 010 or 011 (2, 4 or 8 beats) keeps the column bits above the low 1, 2 or 3 bits fixed. The low bits are start+beat modulo the length, so the burst wraps inside its aligned block.
- R4: Interleaved order (`interleave`=1) with length 2, 4 or 8 gives low bits equal to the starting low bits XOR the beat number. For example, start 0x2D at length 8 gives 2D,2C,2F,2E,29,28,2B,2A.
- R5: Code 000 gives exactly one beat at `start_col`, whatever the value of `interleave`, and no error.
- R6: Code 111 with sequential order is a full-page burst. The column is start+beat modulo 256, it continues past 256 beats, and `last` stays 0 throughout.
- R7: `terminate` sampled high during a full-page beat makes that beat the final one, so `valid` is 0 on the next cycle. During a fixed-length burst, `terminate` has no effect.
- R8: When `wr_single`=1, a start with `is_write`=1 gives a single beat. A start with `is_write`=0 keeps the programmed length.
- R9: Codes 100, 101 and 110, and code 111 with `interleave`=1, set `mode_err` to 1 and give a single beat at `start_col`. `mode_err` holds the value set by the latest start until the next start.
- R10: A `start` during an active burst abandons it, and the next cycle presents the new `start_col` as beat 0 of a new burst with the new settings.
- R11: `last` is 1 only on the final beat of a fixed-length burst. `valid` is 0 on the following cycle unless a new start was given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst with the inputs below |
| start_col | input | 8 | Starting column |
| is_write | input | 1 | 1 for a write burst, 0 for a read |
| bl_code | input | 3 | Burst length code |
| interleave | input | 1 | 0 sequential, 1 interleaved order |
| wr_single | input | 1 | Writes are single-beat when 1 |
| terminate | input | 1 | Stop a full-page burst after the current beat |
| col | output | 8 | Column of the current beat |
| valid | output | 1 | A beat is presented this cycle |
| last | output | 1 | Final beat of a fixed-length burst |
| mode_err | output | 1 | Settings of the current burst were not allowed |

## Verification
Starting columns are chosen in the middle of their aligned block, so a wrap occurs partway through the burst. This distinguishes wrapping inside the block from a plain increment, and it separates the sequential sequence from the XOR sequence for the same start. Full-page bursts start just below the top column and run past 256 beats, which exposes both the wrap to column 0 and any false last flag. Reads and writes are given identical mode fields, which separates the single-write rule from the length decode. A restart in the middle of a burst shows whether the old beat counter or block base leaks into the new burst.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

    typedef enum logic [2:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd4
    } len_sel_e;

endpackage

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode
    import burst_colgen_pkg::*;
(
    input  logic [2:0] bl_code,
    input  logic       interleave,
    input  logic       is_write,
    input  logic       wr_single,
    output len_sel_e   len_sel,
    output logic       mode_err
);

    len_sel_e raw_len;
    logic     raw_err;

    always_comb begin
        raw_len = LEN_1;
        raw_err = 1'b0;
        unique case (bl_code)
            3'b000: raw_len = LEN_1;
            3'b001: raw_len = LEN_2;
            3'b010: raw_len = LEN_4;
            3'b011: raw_len = LEN_8;
            3'b111: begin
                if (interleave) begin
                    raw_err = 1'b1;
                end else begin
                    raw_len = LEN_PAGE;
                end
            end
            default: raw_err = 1'b1;
        endcase
    end

    always_comb begin
        mode_err = raw_err;
        len_sel  = (is_write && wr_single) ? LEN_1 : raw_len;
    end

endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  len_sel_e         len_sel,
    input  logic             interleave,
    output logic [COL_W-1:0] col,
    output logic [COL_W-1:0] blk_mask
);

    logic [COL_W-1:0] offs;

    always_comb begin
        unique case (len_sel)
            LEN_1:    blk_mask = '0;
            LEN_2:    blk_mask = COL_W'(1);
            LEN_4:    blk_mask = COL_W'(3);
            LEN_8:    blk_mask = COL_W'(7);
            LEN_PAGE: blk_mask = '1;
            default:  blk_mask = '0;
        endcase
    end

    always_comb begin
        offs = interleave ? (base ^ beat) : (base + beat);
        col  = (base & ~blk_mask) | (offs & blk_mask);
    end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             is_write,
    input  logic [2:0]       bl_code,
    input  logic             interleave,
    input  logic             wr_single,
    input  logic             terminate,
    output logic [COL_W-1:0] col,
    output logic             valid,
    output logic             last,
    output logic             mode_err
);

    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] cnt;
        len_sel_e         len;
        logic             il;
        logic             err;
    } bcg_state_t;

    bcg_state_t st_d, st_q;

    len_sel_e         dec_len;
    logic             dec_err;
    logic [COL_W-1:0] cur_col;
    logic [COL_W-1:0] cur_mask;
    logic             final_beat;

    bcg_mode_decode u_decode (
        .bl_code    (bl_code),
        .interleave (interleave),
        .is_write   (is_write),
        .wr_single  (wr_single),
        .len_sel    (dec_len),
        .mode_err   (dec_err)
    );

    bcg_addr_calc #(.COL_W(COL_W)) u_addr (
        .base       (st_q.base),
        .beat       (st_q.cnt),
        .len_sel    (st_q.len),
        .interleave (st_q.il),
        .col        (cur_col),
        .blk_mask   (cur_mask)
    );

    always_comb begin
        final_beat = st_q.active && (st_q.len != LEN_PAGE)
                     && ((st_q.cnt & cur_mask) == cur_mask);

        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.base   = start_col;
            st_d.cnt    = '0;
            st_d.len    = dec_len;
            st_d.il     = interleave;
            st_d.err    = dec_err;
        end else if (st_q.active) begin
            if (st_q.len == LEN_PAGE && terminate) begin
                st_d.active = 1'b0;
            end else if (final_beat) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col      = cur_col;
    assign valid    = st_q.active;
    assign last     = final_beat;
    assign mode_err = st_q.err;

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             is_write,
    input logic [2:0]       bl_code,
    input logic             interleave,
    input logic             wr_single,
    input logic [COL_W-1:0] col,
    input logic             valid,
    input logic             last,
    input logic             mode_err
);

    // R11
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid);

    // R11
    ends_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !valid);

    // R10
    restart_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (valid && col == $past(start_col)));

    // R8
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && is_write && wr_single) |=> last);

    // R5
    one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && bl_code == 3'b000) |=> (last && !mode_err));

    // R9
    reserved_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && bl_code[2] && !(bl_code == 3'b111 && !interleave)) |=> (mode_err && last));

    // R6
    page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && bl_code == 3'b111 && !interleave && !(is_write && wr_single)) |=> !last);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(mode_err));

endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_col  (start_col),
    .is_write   (is_write),
    .bl_code    (bl_code),
    .interleave (interleave),
    .wr_single  (wr_single),
    .col        (col),
    .valid      (valid),
    .last       (last),
    .mode_err   (mode_err)
);

// File: tb/burst_colgen_bench.sv
module burst_colgen_bench;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic       is_write = 1'b0;
    logic [2:0] bl_code = '0;
    logic       interleave = 1'b0;
    logic       wr_single = 1'b0;
    logic       terminate = 1'b0;
    logic [7:0] col;
    logic       valid;
    logic       last;
    logic       mode_err;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    burst_colgen u_burst_colgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_col  (start_col),
        .is_write   (is_write),
        .bl_code    (bl_code),
        .interleave (interleave),
        .wr_single  (wr_single),
        .terminate  (terminate),
        .col        (col),
        .valid      (valid),
        .last       (last),
        .mode_err   (mode_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge where beat 0 is shown.
    task automatic launch(input logic [7:0] c, input logic [2:0] code,
                          input logic il, input logic wr, input logic ws);
        start      = 1'b1;
        start_col  = c;
        bl_code    = code;
        interleave = il;
        is_write   = wr;
        wr_single  = ws;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_burst(input string req, input logic [7:0] e [8], input int n);
        for (int i = 0; i < n; i++) begin
            chk(req, "valid", int'(valid), 1);
            chk(req, "col", int'(col), int'(e[i]));
            chk(req, "last", int'(last), (i == n - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk(req, "valid after end", int'(valid), 0);
    endtask

    task automatic t_reset();
        chk("R1", "valid in reset", int'(valid), 0);
        chk("R1", "last in reset", int'(last), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", int'(valid), 0);
        chk("R1", "last after reset", int'(last), 0);
        chk("R1", "err after reset", int'(mode_err), 0);
    endtask

    task automatic t_seq();
        logic [7:0] e [8];
        e = '{8'h13, 8'h12, 0, 0, 0, 0, 0, 0};
        launch(8'h13, 3'b001, 1'b0, 1'b0, 1'b0);
        chk("R2", "first col", int'(col), 8'h13);
        run_burst("R3", e, 2);
        e = '{8'h4E, 8'h4F, 8'h4C, 8'h4D, 0, 0, 0, 0};
        launch(8'h4E, 3'b010, 1'b0, 1'b0, 1'b0);
        run_burst("R3", e, 4);
        e = '{8'h2D, 8'h2E, 8'h2F, 8'h28, 8'h29, 8'h2A, 8'h2B, 8'h2C};
        launch(8'h2D, 3'b011, 1'b0, 1'b0, 1'b0);
        run_burst("R3", e, 8);
    endtask

    task automatic t_il();
        logic [7:0] e [8];
        e = '{8'h2D, 8'h2C, 8'h2F, 8'h2E, 8'h29, 8'h28, 8'h2B, 8'h2A};
        launch(8'h2D, 3'b011, 1'b1, 1'b0, 1'b0);
        run_burst("R4", e, 8);
        e = '{8'h4D, 8'h4C, 8'h4F, 8'h4E, 0, 0, 0, 0};
        launch(8'h4D, 3'b010, 1'b1, 1'b0, 1'b0);
        run_burst("R4", e, 4);
    endtask

    task automatic t_len1();
        logic [7:0] e [8];
        e = '{8'hB7, 0, 0, 0, 0, 0, 0, 0};
        launch(8'hB7, 3'b000, 1'b1, 1'b0, 1'b0);
        chk("R5", "err", int'(mode_err), 0);
        run_burst("R5", e, 1);
    endtask

    task automatic t_page();
        launch(8'hFD, 3'b111, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 262; i++) begin
            chk("R6", "valid", int'(valid), 1);
            chk("R6", "col", int'(col), (8'hFD + i) % 256);
            chk("R6", "last", int'(last), 0);
            if (i == 261) terminate = 1'b1;
            @(negedge clk);
        end
        terminate = 1'b0;
        chk("R7", "valid after terminate", int'(valid), 0);
    endtask

    task automatic t_term_fixed();
        logic [7:0] e [8];
        e = '{8'h62, 8'h63, 8'h60, 8'h61, 0, 0, 0, 0};
        terminate = 1'b1;
        launch(8'h62, 3'b010, 1'b0, 1'b0, 1'b0);
        run_burst("R7", e, 4);
        terminate = 1'b0;
    endtask

    task automatic t_write_single();
        logic [7:0] e [8];
        e = '{8'h35, 0, 0, 0, 0, 0, 0, 0};
        launch(8'h35, 3'b011, 1'b0, 1'b1, 1'b1);
        run_burst("R8", e, 1);
        e = '{8'h35, 8'h36, 8'h37, 8'h34, 0, 0, 0, 0};
        launch(8'h35, 3'b010, 1'b0, 1'b0, 1'b1);
        run_burst("R8", e, 4);
    endtask

    task automatic t_err();
        logic [7:0] e [8];
        e = '{8'h91, 0, 0, 0, 0, 0, 0, 0};
        launch(8'h91, 3'b100, 1'b0, 1'b0, 1'b0);
        chk("R9", "err reserved", int'(mode_err), 1);
        run_burst("R9", e, 1);
        chk("R9", "err held", int'(mode_err), 1);
        launch(8'h91, 3'b111, 1'b1, 1'b0, 1'b0);
        chk("R9", "err page il", int'(mode_err), 1);
        run_burst("R9", e, 1);
        launch(8'h91, 3'b000, 1'b0, 1'b0, 1'b0);
        chk("R9", "err cleared", int'(mode_err), 0);
        run_burst("R9", e, 1);
    endtask

    task automatic t_restart();
        logic [7:0] e [8];
        launch(8'h10, 3'b011, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            chk("R10", "old col", int'(col), 8'h10 + i);
            @(negedge clk);
        end
        chk("R10", "old col", int'(col), 8'h13);
        e = '{8'h80, 8'h81, 0, 0, 0, 0, 0, 0};
        launch(8'h80, 3'b001, 1'b0, 1'b0, 1'b0);
        run_burst("R10", e, 2);
        chk("R11", "idle last", int'(last), 0);
    endtask

    initial begin
        #(CLK_P * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_seq();
        t_il();
        t_len1();
        t_page();
        t_term_fixed();
        t_write_single();
        t_err();
        t_restart();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule